// File: doc/BRIEF.md
# Multi-Mode Shift and Rotate Unit

This unit is the shift stage of a 32-bit integer execution datapath. It takes one data word and moves its bits by a distance of 0 to 31 places. The direction and the kind of move come from an operation select: logical left, logical right, arithmetic right, rotate right or rotate left. The word to be shifted comes from the second source register of the instruction. The first source register is not used as the data input.

The distance comes from one of two places. It can be the 5-bit shift field of the instruction word, or it can be a 32-bit register value, of which only the low 5 bits are used. A single amount-source input picks between the two. All five operations accept either source. Decode and register-file reads are done upstream. The result is registered, so it appears one clock after the inputs are presented.

Internally a single right rotator does all the bit movement. Left moves use the complementary distance. A mask-and-fill stage then turns the rotation into a shift by clearing vacated positions or filling them with the sign bit.

Top module: `shf_unit`

## Requirements
- R1: While `rst_n` is low, `result` is forced to 0, and it stays 0 until the first clock edge with `rst_n` high.
- R2: `result` is registered. It shows the value computed from the inputs sampled at the previous rising edge, and it does not change between edges.
- R3: When `amt_src` is 0 the distance is `imm_amt`. When `amt_src` is 1 the distance is `reg_amt[4:0]`. Bits 31:5 of `reg_amt`, and the input that is not selected, have no effect on `result`.
- R4: `op_sel` = 3'd0 shifts left by the distance and fills the vacated low bits with 0.
- R5: `op_sel` = 3'd1 shifts right by the distance and fills the vacated high bits with 0 (0xFFFFFFF8 by 2 gives 0x3FFFFFFE).
- R6: `op_sel` = 3'd2 shifts right by the distance and copies bit 31 of the operand into every vacated high bit (0xFFFFFFF8 by 2 gives 0xFFFFFFFE).
- R7: `op_sel` = 3'd3 rotates right: bits leaving bit 0 re-enter at bit 31.
- R8: `op_sel` = 3'd4 rotates left: bits leaving bit 31 re-enter at bit 0.
- R9: A distance of 0 returns the operand unchanged for every operation.
- R10: `op_sel` values 3'd5, 3'd6 and 3'd7 return the operand unchanged, whatever the distance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation code (0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right, 4 rotate left) |
| amt_src | input | 1 | 0 selects the instruction shift field, 1 selects the register amount |
| imm_amt | input | 5 | Shift distance taken from the instruction field |
| reg_amt | input | 32 | Register-supplied distance; only the low 5 bits count |
| operand | input | 32 | Data word taken from the second source register |
| result | output | 32 | Registered shifted or rotated word |

## Verification
The following properties are checked on every cycle:
- a zero distance passes the operand through;
- a left logical shift clears bit 0 and a right logical shift clears bit 31;
- an arithmetic shift keeps the sign bit;
- a rotation keeps the number of set bits;
- reserved codes pass the operand through;
- a result held constant when the inputs are held constant.

These properties cannot show that each bit lands in the right position, or that the unselected amount source and the upper register-amount bits are really ignored. Only the bench's sweep shows those. It covers every operation code, every distance and both sources, with decoy values on the unused amount inputs, and compares each result against independently written arithmetic.

// File: rtl/shf_pkg.sv
package shf_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    SHF_LL  = 3'd0,
    SHF_RL  = 3'd1,
    SHF_RA  = 3'd2,
    SHF_ROR = 3'd3,
    SHF_ROL = 3'd4
  } shf_op_e;

  // Codes 0..4 are defined operations; 5..7 are pass-through.
  function automatic logic op_known(logic [OP_W-1:0] code);
    return code <= 3'd4;
  endfunction

  // Left-moving operations are mapped onto the right rotator.
  function automatic logic op_moves_left(logic [OP_W-1:0] code);
    return (code == SHF_LL) || (code == SHF_ROL);
  endfunction

  // Shift kinds clear vacated positions; rotates do not.
  function automatic logic op_masks(logic [OP_W-1:0] code);
    return (code == SHF_LL) || (code == SHF_RL) || (code == SHF_RA);
  endfunction

endpackage

// File: rtl/shf_amt_pick.sv
module shf_amt_pick #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              amt_src,
  input  logic [AMT_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] reg_amt,
  output logic [AMT_W-1:0]  amt
);

  localparam logic [DATA_W-1:0] MODULUS = DATA_W;

  logic [DATA_W-1:0] reg_wrapped;

  // DATA_W is a power of two, so the remainder keeps only the low bits.
  always_comb begin
    reg_wrapped = reg_amt % MODULUS;
    amt = amt_src ? reg_wrapped[AMT_W-1:0] : imm_amt;
  end

endmodule

// File: rtl/shf_rotr.sv
module shf_rotr #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] stage [AMT_W+1];

  assign stage[0] = din;

  // One stage per amount bit; stage k rotates by 2**k when its bit is set.
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [DATA_W-1:0] turned;
    assign turned = {stage[k][STEP-1:0], stage[k][DATA_W-1:STEP]};
    assign stage[k+1] = amt[k] ? turned : stage[k];
  end

  assign dout = stage[AMT_W];

endmodule

// File: rtl/shf_fill.sv
module shf_fill
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rot_in,
  input  logic [AMT_W-1:0]  amt,
  input  logic [OP_W-1:0]   code,
  input  logic              sign_bit,
  output logic [DATA_W-1:0] keep_mask,
  output logic [DATA_W-1:0] shaped
);

  // Positions that survive a right shift by n.
  function automatic logic [DATA_W-1:0] right_keep(logic [AMT_W-1:0] n);
    return {DATA_W{1'b1}} >> n;
  endfunction

  // Positions that survive a left shift by n.
  function automatic logic [DATA_W-1:0] left_keep(logic [AMT_W-1:0] n);
    return {DATA_W{1'b1}} << n;
  endfunction

  logic [DATA_W-1:0] fill_bits;

  always_comb begin
    if (!op_masks(code))      keep_mask = {DATA_W{1'b1}};
    else if (code == SHF_LL)  keep_mask = left_keep(amt);
    else                      keep_mask = right_keep(amt);

    fill_bits = ((code == SHF_RA) && sign_bit) ? ~keep_mask : '0;
    shaped    = (rot_in & keep_mask) | fill_bits;
  end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_sel,
  input  logic              amt_src,
  input  logic [AMT_W-1:0]  imm_amt,
  input  logic [DATA_W-1:0] reg_amt,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);

  // Named internal events, also used by the bound checker.
  logic [AMT_W-1:0]  eff_amt_w;
  logic [AMT_W-1:0]  rot_amt_w;
  logic [DATA_W-1:0] rot_out_w;
  logic [DATA_W-1:0] keep_mask_w;
  logic [DATA_W-1:0] shaped_w;
  logic [DATA_W-1:0] next_res_w;
  logic              op_known_w;

  shf_amt_pick #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_pick (
    .amt_src (amt_src),
    .imm_amt (imm_amt),
    .reg_amt (reg_amt),
    .amt     (eff_amt_w)
  );

  // A left move by n is a right rotate by (DATA_W - n) mod DATA_W.
  assign rot_amt_w = op_moves_left(op_sel) ? (AMT_W'(0) - eff_amt_w) : eff_amt_w;

  shf_rotr #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rot (
    .din  (operand),
    .amt  (rot_amt_w),
    .dout (rot_out_w)
  );

  shf_fill #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_fill (
    .rot_in    (rot_out_w),
    .amt       (eff_amt_w),
    .code      (op_sel),
    .sign_bit  (operand[DATA_W-1]),
    .keep_mask (keep_mask_w),
    .shaped    (shaped_w)
  );

  assign op_known_w = op_known(op_sel);
  assign next_res_w = op_known_w ? shaped_w : operand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else        result <= next_res_w;
  end

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_sel,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] result,
  input logic [AMT_W-1:0]  eff_amt
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> result == '0);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(op_sel) && $stable(operand) && $stable(eff_amt))
      |=> $stable(result));

  assert_left_lsb_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd0 && eff_amt != '0) |=> result[0] == 1'b0);

  assert_right_msb_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd1 && eff_amt != '0) |=> result[DATA_W-1] == 1'b0);

  assert_arith_sign_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd2) |=> result[DATA_W-1] == $past(operand[DATA_W-1]));

  assert_rotate_bits_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 3'd3 || op_sel == 3'd4) |=> $countones(result) == $countones($past(operand)));

  assert_zero_amount_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_amt == '0) |=> result == $past(operand));

  assert_reserved_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 3'd4) |=> result == $past(operand));

endmodule

bind shf_unit shf_unit_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_sel  (op_sel),
  .operand (operand),
  .result  (result),
  .eff_amt (eff_amt_w)
);

// File: tb/sim_shf_unit.sv
module sim_shf_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        amt_src = 1'b0;
  logic [4:0]  imm_amt = '0;
  logic [31:0] reg_amt = '0;
  logic [31:0] operand = '0;
  logic [31:0] result;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  shf_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .amt_src(amt_src),
    .imm_amt(imm_amt), .reg_amt(reg_amt), .operand(operand), .result(result)
  );

  function automatic logic [31:0] model(int op, int n, logic [31:0] x);
    logic [63:0] twin;
    twin = {x, x};
    case (op)
      0: return x << n;
      1: return x >> n;
      2: return 32'($signed(x) >>> n);
      3: return 32'(twin >> n);
      4: begin twin = twin << n; return twin[63:32]; end
      default: return x;
    endcase
  endfunction

  function automatic string tag_of(int op, int n);
    if (n == 0) return "R9";
    case (op)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: result=%h expected=%h", req, got, exp);
    end
  endtask

  // Drive at a falling edge, check at the next falling edge (one register).
  task automatic run_vec(int op, int src, int n, logic [31:0] x, string req);
    @(negedge clk);
    op_sel  = 3'(op);
    amt_src = src[0];
    operand = x;
    if (src == 0) begin
      imm_amt = 5'(n);
      reg_amt = {27'h5A5A5A5, 5'((n + 7) % 32)};   // decoy for R3
    end else begin
      imm_amt = 5'((n + 13) % 32);                 // decoy for R3
      reg_amt = {27'h7C3E1F0 ^ 27'(n), 5'(n)};
    end
    @(negedge clk);
    check(req, result, model(op, n, x));
  endtask

  logic [31:0] pats [6] = '{32'hFFFFFFF8, 32'h80000001, 32'h12345678,
                            32'h7FFFFFFF, 32'hA5C30F96, 32'h00000001};

  initial begin
    repeat (3) @(negedge clk);
    check("R1", result, 32'h0);                     // R1 reset clear
    operand = 32'hDEADBEEF; op_sel = 3'd7;
    @(negedge clk);
    check("R1", result, 32'h0);                     // R1 still in reset
    rst_n = 1'b1;

    // R5 / R6 worked examples
    run_vec(1, 0, 2, 32'hFFFFFFF8, "R5");
    check("R5", result, 32'h3FFFFFFE);
    run_vec(2, 1, 2, 32'hFFFFFFF8, "R6");
    check("R6", result, 32'hFFFFFFFE);

    // R2: new inputs do not show before the next rising edge
    @(negedge clk);
    operand = 32'h0F0F0F0F; op_sel = 3'd7;
    #1;
    check("R2", result, 32'hFFFFFFFE);
    @(negedge clk);
    check("R2", result, 32'h0F0F0F0F);

    // Sweep: every code, distance, source (R3 decoys), pattern
    for (int op = 0; op < 8; op++)
      for (int n = 0; n < 32; n++)
        for (int src = 0; src < 2; src++)
          for (int p = 0; p < 6; p++)
            run_vec(op, src, n, pats[p], {tag_of(op, n), "/R3"});

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: result=%h expected=completion", result);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule